// File: doc/BRIEF.md
# Mode-Programmable Carry-Chain Arithmetic Unit

The unit is a W-bit signed arithmetic slice built on one ripple carry chain. The bit function sees only one A bit, one B bit and a two-bit mode. From these it forms a propagate term and a generate term. A carry multiplexer moves the carry up the chain, and a final XOR combines the propagate term with the incoming carry to give the sum bit. Each of the four mode codes is bound at elaboration to one of five operations:

- increment by carry: A + CIN
- add: A + B + CIN
- subtract: A - B - CIN
- double: A + A + CIN
- fill: every bit equals CIN

An optional kill feature treats one mode bit as an enable for operand A. When that bit is low, A becomes zero, so the add code gives B + CIN and the subtract code gives the negation -B - CIN.

Operands enter through a valid/ready stream, and results leave on a second valid/ready stream through one output register. The output register accepts a new operand whenever it is empty, or when the current result is consumed in the same cycle. A held result does not change while `out_ready` is low. The `use_acc` control pin feeds the registered result back as operand A. With this feedback the unit works as an accumulator that can be cleared synchronously: one code adds B into the register, and a fill code with CIN = 0 zeroes it.

Top module: `mcc_unit`

## Requirements
- R1: An active-high synchronous `rst` clears `out_valid`, `res`, `cout` and `ovf` to 0 at the next rising clock edge.
- R2: The add operation returns res = (A + B + CIN) mod 2^W. `cout` is bit W of the unsigned sum.
- R3: The subtract operation returns res = (A - B - CIN) mod 2^W, computed as A + ~B + ~CIN. `cout` is bit W of that sum, so 1 means no borrow.
- R4: The double operation returns {A[W-2:0], CIN}, which is a left shift with CIN entering bit 0. `cout` equals A[W-1].
- R5: The fill operation makes every bit of `res` equal to CIN. `cout` equals ~CIN.
- R6: The increment operation returns res = (A + CIN) mod 2^W. `cout` is bit W of the unsigned sum.
- R7: `ovf` is 1 only for add, subtract and double, and only when the two's-complement result leaves the signed W-bit range. It is 0 for increment and fill.
- R8: When KILL_EN = 1 and mode[KILL_BIT] = 0, operand A is taken as zero before the operation. With the default map, code 0 then yields -B - CIN.
- R9: Mode code k runs operation OP_Mk. Default map: 0 subtract, 1 add, 2 fill, 3 double, KILL_EN = 1, KILL_BIT = 0. Operation codes: 0 increment, 1 add, 2 subtract, 3 double, 4 fill.
- R10: `in_ready` = !out_valid || out_ready. An operand is accepted when `in_valid` && `in_ready`, and its result appears with `out_valid` one clock later. While `out_valid` && !`out_ready`, the outputs hold.
- R11: With `use_acc` = 1, operand A is the current registered `res`. With the default map, code 1 adds B into the register, and code 2 with CIN = 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Operand beat can be taken |
| a | input | W | Operand A, signed |
| b | input | W | Operand B, signed |
| cin | input | 1 | Carry input |
| mode | input | 2 | Operation code |
| use_acc | input | 1 | Use registered result as operand A |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| res | output | W | Registered result |
| cout | output | 1 | Registered carry out of the chain |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
Every result, together with `cout` and `ovf`, is due exactly one rising edge after the cycle in which its operand is accepted. A reset clear shows up one edge after `rst` is sampled high. `in_ready` is combinational, so it is due in the same cycle as `out_valid` and `out_ready`. The bench drives each beat after a falling edge and advances a behavioural model by that one edge. It then compares `in_ready` before the edge, and `out_valid` with the result fields after the following falling edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [2:0] {
    OP_INC   = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_DBL   = 3'd3,
    OP_FILL  = 3'd4
  } op_e;

  // Select the operation bound to a mode code.
  function automatic op_e pick_op(input logic [1:0] m,
                                  input op_e o0, input op_e o1,
                                  input op_e o2, input op_e o3);
    case (m)
      2'd0:    return o0;
      2'd1:    return o1;
      2'd2:    return o2;
      default: return o3;
    endcase
  endfunction

  // Operations whose chain input is the inverted carry.
  function automatic logic inverts_cin(input op_e op);
    return (op == OP_SUB) || (op == OP_FILL);
  endfunction

  // Operations that report signed overflow.
  function automatic logic reports_ovf(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_DBL);
  endfunction

endpackage

// File: rtl/mcc_bit_lut.sv
// Per-bit function: sees only one A bit, one B bit and the mode pins.
module mcc_bit_lut
  import mcc_pkg::*;
#(
  parameter op_e OP_M0    = OP_SUB,
  parameter op_e OP_M1    = OP_ADD,
  parameter op_e OP_M2    = OP_FILL,
  parameter op_e OP_M3    = OP_DBL,
  parameter bit  KILL_EN  = 1'b1,
  parameter int  KILL_BIT = 0
) (
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic [1:0] mode,
  output logic       prop,
  output logic       gen
);
  localparam int KB = (KILL_BIT != 0) ? 1 : 0;

  op_e  op;
  logic a_eff;

  always_comb begin
    op    = pick_op(mode, OP_M0, OP_M1, OP_M2, OP_M3);
    a_eff = (KILL_EN && !mode[KB]) ? 1'b0 : a_bit;
    case (op)
      OP_INC:  begin prop = a_eff;            gen = 1'b0;  end
      OP_ADD:  begin prop = a_eff ^ b_bit;    gen = a_eff; end
      OP_SUB:  begin prop = ~(a_eff ^ b_bit); gen = a_eff; end
      OP_DBL:  begin prop = 1'b0;             gen = a_eff; end
      default: begin prop = 1'b1;             gen = 1'b0;  end
    endcase
  end
endmodule

// File: rtl/mcc_ripple.sv
// Dedicated carry multiplexers and sum XORs around a row of bit functions.
module mcc_ripple
  import mcc_pkg::*;
#(
  parameter int  W        = 8,
  parameter op_e OP_M0    = OP_SUB,
  parameter op_e OP_M1    = OP_ADD,
  parameter op_e OP_M2    = OP_FILL,
  parameter op_e OP_M3    = OP_DBL,
  parameter bit  KILL_EN  = 1'b1,
  parameter int  KILL_BIT = 0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   mode,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_msb,
  output logic         c_out
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;

  for (genvar i = 0; i < W; i++) begin : g_bit
    mcc_bit_lut #(
      .OP_M0(OP_M0), .OP_M1(OP_M1), .OP_M2(OP_M2), .OP_M3(OP_M3),
      .KILL_EN(KILL_EN), .KILL_BIT(KILL_BIT)
    ) u_lut (
      .a_bit(a[i]),
      .b_bit(b[i]),
      .mode (mode),
      .prop (prop[i]),
      .gen  (gen[i])
    );
  end

  always_comb begin
    logic carry;
    carry = c_in;
    c_msb = 1'b0;
    sum   = '0;
    for (int i = 0; i < W; i++) begin
      sum[i] = prop[i] ^ carry;
      if (i == W - 1) c_msb = carry;
      carry = prop[i] ? carry : gen[i];
    end
    c_out = carry;
  end
endmodule

// File: rtl/mcc_ctrl.sv
// Chain-entry carry and overflow enable derived from the mode pins.
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter op_e OP_M0 = OP_SUB,
  parameter op_e OP_M1 = OP_ADD,
  parameter op_e OP_M2 = OP_FILL,
  parameter op_e OP_M3 = OP_DBL
) (
  input  logic [1:0] mode,
  input  logic       cin,
  output logic       chain_cin,
  output logic       ovf_en
);
  op_e op;

  always_comb begin
    op        = pick_op(mode, OP_M0, OP_M1, OP_M2, OP_M3);
    chain_cin = cin ^ inverts_cin(op);
    ovf_en    = reports_ovf(op);
  end
endmodule

// File: rtl/mcc_unit.sv
module mcc_unit
  import mcc_pkg::*;
#(
  parameter int  W        = 8,
  parameter op_e OP_M0    = OP_SUB,
  parameter op_e OP_M1    = OP_ADD,
  parameter op_e OP_M2    = OP_FILL,
  parameter op_e OP_M3    = OP_DBL,
  parameter bit  KILL_EN  = 1'b1,
  parameter int  KILL_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [1:0]   mode,
  input  logic         use_acc,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] opa;
  logic [W-1:0] sum;
  logic         chain_cin;
  logic         ovf_en;
  logic         c_msb;
  logic         c_out;
  logic         load;

  assign opa      = use_acc ? res : a;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  mcc_ctrl #(
    .OP_M0(OP_M0), .OP_M1(OP_M1), .OP_M2(OP_M2), .OP_M3(OP_M3)
  ) u_ctrl (
    .mode     (mode),
    .cin      (cin),
    .chain_cin(chain_cin),
    .ovf_en   (ovf_en)
  );

  mcc_ripple #(
    .W(W), .OP_M0(OP_M0), .OP_M1(OP_M1), .OP_M2(OP_M2), .OP_M3(OP_M3),
    .KILL_EN(KILL_EN), .KILL_BIT(KILL_BIT)
  ) u_chain (
    .a    (opa),
    .b    (b),
    .mode (mode),
    .c_in (chain_cin),
    .sum  (sum),
    .c_msb(c_msb),
    .c_out(c_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      cout      <= 1'b0;
      ovf       <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      res       <= sum;
      cout      <= c_out;
      ovf       <= ovf_en & (c_out ^ c_msb);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mcc_unit_chk.sv
module mcc_unit_chk
  import mcc_pkg::*;
#(
  parameter int  W        = 8,
  parameter op_e OP_M0    = OP_SUB,
  parameter op_e OP_M1    = OP_ADD,
  parameter op_e OP_M2    = OP_FILL,
  parameter op_e OP_M3    = OP_DBL,
  parameter bit  KILL_EN  = 1'b1,
  parameter int  KILL_BIT = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] a,
  input logic         cin,
  input logic [1:0]   mode,
  input logic         use_acc,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] res,
  input logic         cout,
  input logic         ovf
);
  localparam int KB = (KILL_BIT != 0) ? 1 : 0;

  op_e  op_now;
  logic kill_now;
  logic take;
  logic rst_d = 1'b0;

  assign op_now   = pick_op(mode, OP_M0, OP_M1, OP_M2, OP_M3);
  assign kill_now = KILL_EN && !mode[KB];
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs cleared one edge after reset is sampled
  always @(negedge clk)
    if (rst_d) begin
      p_reset_r1: assert (!out_valid && res == '0 && !cout && !ovf);
    end

  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(cout) && $stable(ovf));

  // R10
  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R5
  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    take && op_now == OP_FILL |=> res == {W{$past(cin)}} && cout == !$past(cin));

  // R4
  p_dbl_r4: assert property (@(posedge clk) disable iff (rst)
    take && op_now == OP_DBL && !kill_now && !use_acc
      |=> res == {$past(a[W-2:0]), $past(cin)} && cout == $past(a[W-1]));

  // R7
  p_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    take && (op_now == OP_INC || op_now == OP_FILL) |=> !ovf);
endmodule

bind mcc_unit mcc_unit_chk #(
  .W(W), .OP_M0(OP_M0), .OP_M1(OP_M1), .OP_M2(OP_M2), .OP_M3(OP_M3),
  .KILL_EN(KILL_EN), .KILL_BIT(KILL_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .a        (a),
  .cin      (cin),
  .mode     (mode),
  .use_acc  (use_acc),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .res      (res),
  .cout     (cout),
  .ovf      (ovf)
);

// File: tb/mcc_unit_test.sv
module mcc_unit_test;
  import mcc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BW         = 8;
  localparam int MASK       = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [BW-1:0] a = '0;
  logic [BW-1:0] b = '0;
  logic          cin = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          use_acc = 1'b0;
  logic          out_ready = 1'b1;

  logic          rdy   [2];
  logic          vld   [2];
  logic [BW-1:0] rs    [2];
  logic          co    [2];
  logic          ov    [2];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Reference model state per instance
  bit      mv    [2];
  int      mres  [2];
  int      mco   [2];
  int      mov   [2];
  string   mtag  [2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Default map instance
  mcc_unit #(.W(BW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[0]),
    .a(a), .b(b), .cin(cin), .mode(mode), .use_acc(use_acc),
    .out_valid(vld[0]), .out_ready(out_ready),
    .res(rs[0]), .cout(co[0]), .ovf(ov[0])
  );

  // Alternate map: increment, add, subtract, fill; no kill
  mcc_unit #(
    .W(BW), .OP_M0(OP_INC), .OP_M1(OP_ADD), .OP_M2(OP_SUB), .OP_M3(OP_FILL),
    .KILL_EN(1'b0), .KILL_BIT(0)
  ) uut_alt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[1]),
    .a(a), .b(b), .cin(cin), .mode(mode), .use_acc(use_acc),
    .out_valid(vld[1]), .out_ready(out_ready),
    .res(rs[1]), .cout(co[1]), .ovf(ov[1])
  );

  // op codes: 0 inc, 1 add, 2 sub, 3 dbl, 4 fill
  function automatic int op_of(int inst, int m);
    int map0 [4] = '{2, 1, 4, 3};
    int map1 [4] = '{0, 1, 2, 4};
    return (inst == 0) ? map0[m] : map1[m];
  endfunction

  function automatic string tag_of(int op, bit killed);
    if (killed) return "R8";
    case (op)
      0: return "R6";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v >= (1 << (BW - 1))) ? v - (1 << BW) : v;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_accept(int inst, int av, int bv, int c, int m, bit ua, string ph);
    int  ea, op, full, sr;
    bit  killed;
    ea     = ua ? mres[inst] : av;
    op     = op_of(inst, m);
    killed = (inst == 0) && ((m & 1) == 0);
    if (killed) ea = 0;
    case (op)
      0: begin full = ea + c;                        sr = 0; end
      1: begin full = ea + bv + c;                   sr = sgn(ea) + sgn(bv) + c; end
      2: begin full = ea + ((~bv) & MASK) + (1 - c); sr = sgn(ea) - sgn(bv) - c; end
      3: begin full = 2 * ea + c;                    sr = 2 * sgn(ea) + c; end
      default: begin full = ea + ((~ea) & MASK) + (1 - c); sr = 0; end
    endcase
    mres[inst] = full & MASK;
    mco[inst]  = (full >> BW) & 1;
    mov[inst]  = (op >= 1 && op <= 3 &&
                  (sr > (1 << (BW - 1)) - 1 || sr < -(1 << (BW - 1)))) ? 1 : 0;
    mtag[inst] = {ph, "/", tag_of(op, killed)};
  endtask

  task automatic compare_outputs();
    for (int k = 0; k < 2; k++) begin
      check("R10", int'(vld[k]), int'(mv[k]), $sformatf("out_valid inst%0d", k));
      if (mv[k]) begin
        check(mtag[k], int'(rs[k]), mres[k], $sformatf("res inst%0d", k));
        check(mtag[k], int'(co[k]), mco[k], $sformatf("cout inst%0d", k));
        check({mtag[k], "/R7"}, int'(ov[k]), mov[k], $sformatf("ovf inst%0d", k));
      end
    end
  endtask

  // One cycle: drive after a falling edge, advance model, compare after next falling edge.
  task automatic step(bit v, int av, int bv, int c, int m, bit ua, bit ordy, string ph);
    in_valid  = v;
    a         = av[BW-1:0];
    b         = bv[BW-1:0];
    cin       = c[0];
    mode      = m[1:0];
    use_acc   = ua;
    out_ready = ordy;
    #1;
    for (int k = 0; k < 2; k++) begin
      bit exp_rdy;
      exp_rdy = !mv[k] || ordy;
      check("R10", int'(rdy[k]), int'(exp_rdy), $sformatf("in_ready inst%0d", k));
      if (v && exp_rdy) begin
        model_accept(k, av, bv, c, m, ua, ph);
        mv[k] = 1'b1;
      end else if (ordy) begin
        mv[k] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic do_reset();
    rst      = 1'b1;
    in_valid = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      mv[k] = 1'b0; mres[k] = 0; mco[k] = 0; mov[k] = 0;
      check("R1", int'(vld[k]), 0, $sformatf("out_valid after reset inst%0d", k));
      check("R1", int'(rs[k]), 0, $sformatf("res after reset inst%0d", k));
      check("R1", int'(co[k]), 0, $sformatf("cout after reset inst%0d", k));
      check("R1", int'(ov[k]), 0, $sformatf("ovf after reset inst%0d", k));
    end
    rst      = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int pa [6] = '{'h7F, 'h80, 'hFF, 'h40, 'h00, 'h5A};
    int pb [6] = '{'h01, 'h01, 'hFF, 'h3C, 'h00, 'hA5};

    @(negedge clk);
    do_reset();

    // R9: every code against a spread of operand patterns and both carries
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 6; p++)
        for (int c = 0; c < 2; c++)
          step(1'b1, pa[p], pb[p], c, m, 1'b0, 1'b1, "R9");

    // R10: back-pressure and gaps
    for (int k = 0; k < 60; k++)
      step((k % 4) != 1, (k * 37) & MASK, (k * 91 + 5) & MASK, k % 2, k % 4,
           1'b0, (k % 3) != 0, "R10");

    // R11: accumulate with feedback; code 2 clears, code 1 adds
    step(1'b1, 'h33, 'h00, 0, 2, 1'b1, 1'b1, "R11");
    for (int k = 0; k < 4; k++)
      step(1'b1, 'h00, 'h05, 0, 1, 1'b1, 1'b1, "R11");
    step(1'b1, 'h00, 'h70, 1, 1, 1'b1, 1'b1, "R11");
    step(1'b1, 'h00, 'h00, 0, 2, 1'b1, 1'b1, "R11");
    step(1'b1, 'h00, 'h09, 1, 1, 1'b1, 1'b1, "R11");

    // R8: kill under the default map, code 0 negates B
    step(1'b1, 'h55, 'h01, 0, 0, 1'b0, 1'b1, "R8");
    step(1'b1, 'h55, 'h80, 1, 0, 1'b0, 1'b1, "R8");

    // R1: reset in the middle of a held result
    step(1'b1, 'h12, 'h34, 0, 1, 1'b0, 1'b0, "R1");
    do_reset();
    step(1'b0, 0, 0, 0, 0, 1'b0, 1'b1, "R1");

    finish_run();
  end
endmodule